// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

This block resolves how each pin of an 8-bit general-purpose port is driven. The port's own register bits supply a direction, an output value and a pull-up request for every pin. On-chip peripherals can take over some pins. A serial peripheral interface (SPI) uses pins 0 to 3 for slave select, serial clock, master-out data and master-in data. Three timer compare outputs use pins 4 to 6. Pin 7 is always a plain port pin. From the register bits, the SPI enable and its master or slave role, and the compare enables, the block computes the output enable, output value and pull-up enable for each pad. These pad controls are combinational.

On the input side, every pad value passes through a two-flop synchronizer. The synchronized values go to the register read path and to the SPI. A change detector compares each synchronized value with the one from the cycle before. It raises a sticky per-pin flag on a difference, but only for pins whose mask bit is set. Software clears flags by writing ones to the clear strobe. The register file, the SPI shift engine and the timers live outside the block.

Top module: `gpio_port_ovr`

## Requirements
- R1: With SPI disabled and all compare enables low, every pin has oe = its direction bit and drives its port bit.
- R2: SPI enabled as master: pin 3 (master-in) is never driven. Pins 0, 1 and 2 follow their direction bits. Pin 1 drives `spi_sck_drv_i` and pin 2 drives `spi_mosi_drv_i`. Pin 0 drives its port bit.
- R3: SPI enabled as slave: pins 0, 1 and 2 are never driven and drive their port bits as value. Pin 3 follows its direction bit and drives `spi_miso_drv_i`.
- R4: Pins 4, 5 and 6 belong to compare channels 0, 1 and 2. When a pin's direction bit is 1 and its channel enable is 1, it drives the channel's compare value. Otherwise it drives its port bit. Its oe always equals its direction bit.
- R5: The pull-up of each pin equals port bit AND NOT effective oe AND NOT `pud_i`. This applies to pins forced to input as well.
- R6: No pin has oe = 1 while its direction bit is 0.
- R7: `pin_sync_o` equals `pin_i` as sampled two rising edges earlier. The SPI inputs are bits 0 (select), 1 (clock), 2 (master-out) and 3 (master-in) of `pin_sync_o`.
- R8: When a masked-in pin changes at `pin_i`, its flag rises on the third rising edge after the change. Changes on pins whose mask bit is 0 raise no flag.
- R9: A flag stays set until a cycle in which its `chg_clr_i` bit is 1. If a new change and a clear hit the same edge, the flag stays set.
- R10: While reset is asserted, `pin_sync_o` and `chg_flag_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| dir_i | input | 8 | Direction bits, 1 = output |
| port_i | input | 8 | Port output bits, also pull-up request for inputs |
| pud_i | input | 1 | Global pull-up disable |
| spi_en_i | input | 1 | SPI enabled |
| spi_master_i | input | 1 | SPI role, 1 = master |
| spi_sck_drv_i | input | 1 | Serial clock value from SPI in master role |
| spi_mosi_drv_i | input | 1 | Master-out data from SPI in master role |
| spi_miso_drv_i | input | 1 | Master-in data from SPI in slave role |
| cmp_en_i | input | 3 | Compare output enables, channels 0..2 |
| cmp_val_i | input | 3 | Compare output values, channels 0..2 |
| pin_i | input | 8 | Raw pad input values |
| chg_mask_i | input | 8 | Change detection mask |
| chg_clr_i | input | 8 | Write-one-to-clear strobe for flags |
| pad_oe_o | output | 8 | Effective pad output enable |
| pad_do_o | output | 8 | Effective pad output value |
| pad_pu_o | output | 8 | Effective pad pull-up enable |
| pin_sync_o | output | 8 | Synchronized pin values for the read path |
| spi_ss_in_o | output | 1 | Synchronized slave select to SPI |
| spi_sck_in_o | output | 1 | Synchronized serial clock to SPI |
| spi_mosi_in_o | output | 1 | Synchronized master-out data to SPI |
| spi_miso_in_o | output | 1 | Synchronized master-in data to SPI |
| chg_flag_o | output | 8 | Sticky pin change flags |

## Verification
The pad controls are combinational. A wrong override selection appears on `pad_oe_o`, `pad_do_o` or `pad_pu_o` in the same cycle as the input pattern that exposes it. A corrupted synchronizer stage shows on `pin_sync_o` and the SPI inputs two edges after the pad value. A wrong previous-value register or flag register shows on `chg_flag_o` on the third edge: a missing flag, a spurious flag, or a flag that drops without a clear. A lost set-over-clear priority shows only in the cycle where a new change and a clear meet. The bench therefore aligns that collision on purpose.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  // Pin roles; the override logic depends on these positions.
  localparam int PIN_SS       = 0;
  localparam int PIN_SCK      = 1;
  localparam int PIN_MOSI     = 2;
  localparam int PIN_MISO     = 3;
  localparam int PIN_CMP_BASE = 4;

  typedef enum logic [1:0] {
    SPI_OFF    = 2'b00,
    SPI_SLAVE  = 2'b10,
    SPI_MASTER = 2'b11
  } spi_role_e;

  function automatic spi_role_e spi_role(input logic en, input logic mst);
    if (!en)      return SPI_OFF;
    else if (mst) return SPI_MASTER;
    else          return SPI_SLAVE;
  endfunction
endpackage

// File: rtl/gpio_ovr_mux.sv
module gpio_ovr_mux
  import gpio_ovr_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int NUM_CMP = 3
) (
  input  logic [PORT_W-1:0]  dir_i,
  input  logic [PORT_W-1:0]  port_i,
  input  logic               pud_i,
  input  logic               spi_en_i,
  input  logic               spi_master_i,
  input  logic               spi_sck_drv_i,
  input  logic               spi_mosi_drv_i,
  input  logic               spi_miso_drv_i,
  input  logic [NUM_CMP-1:0] cmp_en_i,
  input  logic [NUM_CMP-1:0] cmp_val_i,
  output logic [PORT_W-1:0]  oe_o,
  output logic [PORT_W-1:0]  do_o,
  output logic [PORT_W-1:0]  pu_o
);
  spi_role_e role;
  logic      spi_mst;
  logic      spi_slv;

  always_comb begin
    role    = spi_role(spi_en_i, spi_master_i);
    spi_mst = (role == SPI_MASTER);
    spi_slv = (role == SPI_SLAVE);
  end

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    logic force_in;
    logic alt_sel;
    logic alt_val;

    if (p == PIN_SS) begin : g_ss
      assign force_in = spi_slv;
      assign alt_sel  = 1'b0;
      assign alt_val  = 1'b0;
    end else if (p == PIN_SCK) begin : g_sck
      assign force_in = spi_slv;
      assign alt_sel  = spi_mst;
      assign alt_val  = spi_sck_drv_i;
    end else if (p == PIN_MOSI) begin : g_mosi
      assign force_in = spi_slv;
      assign alt_sel  = spi_mst;
      assign alt_val  = spi_mosi_drv_i;
    end else if (p == PIN_MISO) begin : g_miso
      assign force_in = spi_mst;
      assign alt_sel  = spi_slv;
      assign alt_val  = spi_miso_drv_i;
    end else if (p >= PIN_CMP_BASE && p < PIN_CMP_BASE + NUM_CMP) begin : g_cmp
      assign force_in = 1'b0;
      assign alt_sel  = cmp_en_i[p-PIN_CMP_BASE] & dir_i[p];
      assign alt_val  = cmp_val_i[p-PIN_CMP_BASE];
    end else begin : g_plain
      assign force_in = 1'b0;
      assign alt_sel  = 1'b0;
      assign alt_val  = 1'b0;
    end

    // Effective drive, value and pull-up for this pin
    assign oe_o[p] = dir_i[p] & ~force_in;
    assign do_o[p] = alt_sel ? alt_val : port_i[p];
    assign pu_o[p] = port_i[p] & ~oe_o[p] & ~pud_i;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] prev_q, prev_d;
  logic [WIDTH-1:0] flag_q, flag_d;
  logic [WIDTH-1:0] hit;

  always_comb begin
    hit    = (cur_i ^ prev_q) & mask_i;
    prev_d = cur_i;
    // A fresh hit outranks a clear in the same cycle.
    flag_d = (flag_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_ovr_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int NUM_CMP     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PORT_W-1:0]  dir_i,
  input  logic [PORT_W-1:0]  port_i,
  input  logic               pud_i,
  input  logic               spi_en_i,
  input  logic               spi_master_i,
  input  logic               spi_sck_drv_i,
  input  logic               spi_mosi_drv_i,
  input  logic               spi_miso_drv_i,
  input  logic [NUM_CMP-1:0] cmp_en_i,
  input  logic [NUM_CMP-1:0] cmp_val_i,
  input  logic [PORT_W-1:0]  pin_i,
  input  logic [PORT_W-1:0]  chg_mask_i,
  input  logic [PORT_W-1:0]  chg_clr_i,
  output logic [PORT_W-1:0]  pad_oe_o,
  output logic [PORT_W-1:0]  pad_do_o,
  output logic [PORT_W-1:0]  pad_pu_o,
  output logic [PORT_W-1:0]  pin_sync_o,
  output logic               spi_ss_in_o,
  output logic               spi_sck_in_o,
  output logic               spi_mosi_in_o,
  output logic               spi_miso_in_o,
  output logic [PORT_W-1:0]  chg_flag_o
);
  logic [PORT_W-1:0] sync_val;

  gpio_ovr_mux #(.PORT_W(PORT_W), .NUM_CMP(NUM_CMP)) u_mux (
    .dir_i          (dir_i),
    .port_i         (port_i),
    .pud_i          (pud_i),
    .spi_en_i       (spi_en_i),
    .spi_master_i   (spi_master_i),
    .spi_sck_drv_i  (spi_sck_drv_i),
    .spi_mosi_drv_i (spi_mosi_drv_i),
    .spi_miso_drv_i (spi_miso_drv_i),
    .cmp_en_i       (cmp_en_i),
    .cmp_val_i      (cmp_val_i),
    .oe_o           (pad_oe_o),
    .do_o           (pad_do_o),
    .pu_o           (pad_pu_o)
  );

  gpio_in_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (pin_i),
    .dout_o (sync_val)
  );

  gpio_chg_det #(.WIDTH(PORT_W)) u_chg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (sync_val),
    .mask_i (chg_mask_i),
    .clr_i  (chg_clr_i),
    .flag_o (chg_flag_o)
  );

  assign pin_sync_o    = sync_val;
  assign spi_ss_in_o   = sync_val[PIN_SS];
  assign spi_sck_in_o  = sync_val[PIN_SCK];
  assign spi_mosi_in_o = sync_val[PIN_MOSI];
  assign spi_miso_in_o = sync_val[PIN_MISO];
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk
  import gpio_ovr_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PORT_W-1:0] dir_i,
  input logic              pud_i,
  input logic              spi_en_i,
  input logic              spi_master_i,
  input logic [PORT_W-1:0] pin_i,
  input logic [PORT_W-1:0] chg_mask_i,
  input logic [PORT_W-1:0] chg_clr_i,
  input logic [PORT_W-1:0] pad_oe_o,
  input logic [PORT_W-1:0] pad_pu_o,
  input logic [PORT_W-1:0] pin_sync_o,
  input logic [PORT_W-1:0] chg_flag_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_miso_in_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en_i && spi_master_i) |-> !pad_oe_o[PIN_MISO]);

  assert_slave_inputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en_i && !spi_master_i) |->
      (!pad_oe_o[PIN_SS] && !pad_oe_o[PIN_SCK] && !pad_oe_o[PIN_MOSI]));

  assert_pu_vs_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu_o & pad_oe_o) == '0);

  assert_pud_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pud_i |-> (pad_pu_o == '0));

  assert_drive_needs_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe_o & ~dir_i) == '0);

  if (SYNC_STAGES == 2) begin : g_lat
    assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (pin_sync_o == $past(pin_i, 2)));
  end

  assert_flag_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg_flag_o & ~$past(chg_flag_o) & ~$past(chg_mask_i)) == '0));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(chg_flag_o) & ~$past(chg_clr_i) & ~chg_flag_o) == '0));
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dir_i        (dir_i),
  .pud_i        (pud_i),
  .spi_en_i     (spi_en_i),
  .spi_master_i (spi_master_i),
  .pin_i        (pin_i),
  .chg_mask_i   (chg_mask_i),
  .chg_clr_i    (chg_clr_i),
  .pad_oe_o     (pad_oe_o),
  .pad_pu_o     (pad_pu_o),
  .pin_sync_o   (pin_sync_o),
  .chg_flag_o   (chg_flag_o)
);

// File: tb/gpio_port_ovr_test.sv
`timescale 1ns/100ps
module gpio_port_ovr_test;
  logic       clk;
  logic       rst_n;
  logic [7:0] dir_i, port_i, pin_i, chg_mask_i, chg_clr_i;
  logic       pud_i, spi_en_i, spi_master_i;
  logic       spi_sck_drv_i, spi_mosi_drv_i, spi_miso_drv_i;
  logic [2:0] cmp_en_i, cmp_val_i;
  logic [7:0] pad_oe_o, pad_do_o, pad_pu_o, pin_sync_o, chg_flag_o;
  logic       spi_ss_in_o, spi_sck_in_o, spi_mosi_in_o, spi_miso_in_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  gpio_port_ovr uut (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .port_i(port_i), .pud_i(pud_i),
    .spi_en_i(spi_en_i), .spi_master_i(spi_master_i),
    .spi_sck_drv_i(spi_sck_drv_i), .spi_mosi_drv_i(spi_mosi_drv_i),
    .spi_miso_drv_i(spi_miso_drv_i), .cmp_en_i(cmp_en_i), .cmp_val_i(cmp_val_i),
    .pin_i(pin_i), .chg_mask_i(chg_mask_i), .chg_clr_i(chg_clr_i),
    .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o), .pad_pu_o(pad_pu_o),
    .pin_sync_o(pin_sync_o), .spi_ss_in_o(spi_ss_in_o), .spi_sck_in_o(spi_sck_in_o),
    .spi_mosi_in_o(spi_mosi_in_o), .spi_miso_in_o(spi_miso_in_o),
    .chg_flag_o(chg_flag_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Expected pad controls, written per pin from the requirements.
  function automatic void expect_pads(
    input logic [7:0] dir, port, input logic pud, en, mst, sck, mosi, miso,
    input logic [2:0] ce, cv, output logic [7:0] oe, dv, pu);
    for (int b = 0; b < 8; b++) begin
      logic fin, val;
      fin = 1'b0;
      val = port[b];
      case (b)
        0: fin = en && !mst;
        1: begin fin = en && !mst; if (en && mst) val = sck; end
        2: begin fin = en && !mst; if (en && mst) val = mosi; end
        3: begin fin = en && mst; if (en && !mst) val = miso; end
        4, 5, 6: if (ce[b-4] && dir[b]) val = cv[b-4];
        default: ;
      endcase
      oe[b] = dir[b] && !fin;
      dv[b] = val;
      pu[b] = port[b] && !oe[b] && !pud;
    end
  endfunction

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] eo, ed, ep;
    string tag;
    rst_n = 1'b0;
    dir_i = '0; port_i = '0; pud_i = 1'b0; spi_en_i = 1'b0; spi_master_i = 1'b0;
    spi_sck_drv_i = 1'b0; spi_mosi_drv_i = 1'b0; spi_miso_drv_i = 1'b0;
    cmp_en_i = '0; cmp_val_i = '0; pin_i = 8'h3C; chg_mask_i = '0; chg_clr_i = '0;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 sync in reset", pin_sync_o, 8'h00);
    chk("R10 flags in reset", chg_flag_o, 8'h00);

    // Combinational sweep: R1..R6
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        for (int u = 0; u < 2; u++) begin
          for (int d = 0; d < 256; d++) begin
            logic [7:0] pv;
            pv = 8'(d * 37 + c * 11 + m * 5 + u);
            dir_i = 8'(d); port_i = pv; pud_i = u[0];
            spi_en_i = m[1]; spi_master_i = m[0];
            spi_sck_drv_i = pv[3] ^ 1'b1; spi_mosi_drv_i = pv[6];
            spi_miso_drv_i = ~pv[3];
            cmp_en_i = 3'(c); cmp_val_i = 3'(d) ^ 3'(c) ^ pv[2:0];
            #1;
            expect_pads(dir_i, port_i, pud_i, spi_en_i, spi_master_i, spi_sck_drv_i,
                        spi_mosi_drv_i, spi_miso_drv_i, cmp_en_i, cmp_val_i, eo, ed, ep);
            if (m == 3) tag = "R2";
            else if (m == 2) tag = "R3";
            else if (c != 0) tag = "R4";
            else tag = "R1";
            chk({tag, " oe"}, pad_oe_o, eo);
            chk({tag, " do"}, pad_do_o, ed);
            chk("R5 pull-up", pad_pu_o, ep);
            chk("R6 oe without dir", pad_oe_o & ~dir_i, 8'h00);
          end
        end
      end
    end

    // Sequential part
    @(negedge clk);
    rst_n = 1'b1;
    spi_en_i = 1'b1; spi_master_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 sync value", pin_sync_o, 8'h3C);
    chk("R8 unmasked change ignored", chg_flag_o, 8'h00);
    chk("R7 spi inputs", {4'h0, spi_miso_in_o, spi_mosi_in_o, spi_sck_in_o, spi_ss_in_o}, 8'h0C);

    chg_mask_i = 8'h0F; pin_i = 8'hC3;
    @(negedge clk);
    chk("R7 one edge latency", pin_sync_o, 8'h3C);
    @(negedge clk);
    chk("R7 two edge latency", pin_sync_o, 8'hC3);
    chk("R7 spi inputs after change", {4'h0, spi_miso_in_o, spi_mosi_in_o, spi_sck_in_o, spi_ss_in_o}, 8'h03);
    chk("R8 flag not before third edge", chg_flag_o, 8'h00);
    @(negedge clk);
    chk("R8 flag at third edge, masked", chg_flag_o, 8'h0F);
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", chg_flag_o, 8'h0F);

    chg_clr_i = 8'h03;
    @(negedge clk);
    chg_clr_i = 8'h00;
    chk("R9 partial clear", chg_flag_o, 8'h0C);
    chg_clr_i = 8'h0C;
    @(negedge clk);
    chg_clr_i = 8'h00;
    chk("R9 full clear", chg_flag_o, 8'h00);

    // Change and clear meet at the same edge
    pin_i = 8'hC7;
    @(negedge clk);
    @(negedge clk);
    chg_clr_i = 8'h04;
    @(negedge clk);
    chg_clr_i = 8'h00;
    chk("R9 set beats clear", chg_flag_o, 8'h04);

    // Asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R10 flags on reset", chg_flag_o, 8'h00);
    chk("R10 sync on reset", pin_sync_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule